// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two 8-bit two's-complement operands and returns the full 16-bit signed product. It does not convert the operands to sign-magnitude form. Instead it flips every partial-product bit formed from exactly one operand sign bit, keeps the bit formed from both sign bits as it is, and seeds the sum with constant ones at weights 8 and 15. The partial products are then reduced in a linear chain of full-adder rows that keep their result in carry-save form, one row per multiplier bit. A register sits after every row.

A final carry-propagate adder turns the carry-save pair into the binary product. It is cut into narrow slices, one pipeline stage per slice, so the whole path is exactly 17 registers deep. Each row stage carries forward the operand bits it needs, so every stage works on its own transaction. A new operand pair can enter on every clock. A valid flag travels alongside the data and marks which outputs are real.

Top module: `smul_bw_pipe`

## Requirements
- R1: `product` equals the exact signed product of `op_a` and `op_b` (both read as two's complement), given as a 16-bit two's-complement value, for every one of the 65536 operand pairs.
- R2: Operands sampled at rising edge k produce their product on the outputs right after rising edge k+16, which is 17 rising edges counting the sampling edge.
- R3: A new operand pair is accepted on every clock with no gaps, and each product matches its own operands when pairs arrive back to back.
- R4: `out_valid` equals `in_valid` delayed by the same 17 registers. A cycle with `in_valid` low produces `out_valid` low 17 edges later, whatever the operand values were.
- R5: A synchronous reset (`rst` high at a rising edge) clears every in-flight valid flag, so `out_valid` is low after that edge and stays low until valid input arrives 17 edges later.
- R6: The extreme operands give full-range results with no overflow: -128 × -128 = +16384 (0x4000), -128 × 127 = -16256, 127 × 127 = 16129, and -1 × -1 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_valid | input | 1 | Marks the operand pair presented in this cycle as real |
| op_a | input | 8 | Multiplicand, two's complement |
| op_b | input | 8 | Multiplier, two's complement |
| out_valid | output | 1 | Marks `product` as holding a real result |
| product | output | 16 | Signed product, two's complement |

## Verification
A wrong bit inside one adder row or one carry-propagate slice shows up at the ports 17 edges after the first operand pair that exercises it. Because every operand pair is swept, every flipped or dropped partial-product bit and every wrong correction constant gives a wrong `product` for some pair. A skew register that loses step gives results built from a neighbouring transaction's operands, and this only shows under back-to-back input. A valid flag that runs one stage early or late makes `out_valid` disagree with the delayed `in_valid` pattern as soon as gapped traffic reaches the output.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // True when a partial-product bit a_i*b_j must be complemented:
    // exactly one of the two indices is the sign position.
    function automatic logic bw_flip(input int unsigned i, input int unsigned j,
                                     input int unsigned msb);
        return (i == msb) ^ (j == msb);
    endfunction

    // Constant seed that supplies the correction ones.
    function automatic logic [63:0] bw_seed(input int unsigned op_w);
        logic [63:0] v;
        v = '0;
        v[op_w]       = 1'b1;
        v[2*op_w - 1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bw_row_stage.sv
module bw_row_stage #(
    parameter int unsigned OP_W = 8,
    parameter int unsigned ROW  = 0
) (
    input  logic                  clk,
    input  logic [OP_W-1:0]       a_i,
    input  logic [OP_W-1:0]       b_i,
    input  logic [2*OP_W-1:0]     s_i,
    input  logic [2*OP_W-1:0]     c_i,
    output logic [OP_W-1:0]       a_o,
    output logic [OP_W-1:0]       b_o,
    output logic [2*OP_W-1:0]     s_o,
    output logic [2*OP_W-1:0]     c_o
);
    import smul_pkg::*;

    localparam int unsigned PW = 2 * OP_W;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic [PW-1:0]   s;
        logic [PW-1:0]   c;
    } row_t;

    row_t          row_d, row_q;
    logic [PW-1:0] pp_row;

    always_comb begin
        pp_row = '0;
        for (int unsigned i = 0; i < OP_W; i++) begin
            pp_row[i + ROW] = (a_i[i] & b_i[ROW]) ^ bw_flip(i, ROW, OP_W - 1);
        end
        row_d.a = a_i;
        row_d.b = b_i;
        row_d.s = s_i ^ c_i ^ pp_row;
        row_d.c = ((s_i & c_i) | (s_i & pp_row) | (c_i & pp_row)) << 1;
    end

    always_ff @(posedge clk) begin
        row_q <= row_d;
    end

    assign a_o = row_q.a;
    assign b_o = row_q.b;
    assign s_o = row_q.s;
    assign c_o = row_q.c;

endmodule

// File: rtl/bw_cpa_stage.sv
module bw_cpa_stage #(
    parameter int unsigned PADW = 16,
    parameter int unsigned CH   = 2,
    parameter int unsigned STG  = 0
) (
    input  logic            clk,
    input  logic [PADW-1:0] s_i,
    input  logic [PADW-1:0] c_i,
    input  logic [PADW-1:0] r_i,
    input  logic            cy_i,
    output logic [PADW-1:0] s_o,
    output logic [PADW-1:0] c_o,
    output logic [PADW-1:0] r_o,
    output logic            cy_o
);
    typedef struct packed {
        logic [PADW-1:0] s;
        logic [PADW-1:0] c;
        logic [PADW-1:0] r;
        logic            cy;
    } cpa_t;

    cpa_t          cpa_d, cpa_q;
    logic [CH:0]   slice_sum;

    always_comb begin
        slice_sum = {1'b0, s_i[STG*CH +: CH]} + {1'b0, c_i[STG*CH +: CH]}
                  + {{CH{1'b0}}, cy_i};
        cpa_d.s  = s_i;
        cpa_d.c  = c_i;
        cpa_d.r  = r_i;
        cpa_d.r[STG*CH +: CH] = slice_sum[CH-1:0];
        cpa_d.cy = slice_sum[CH];
    end

    always_ff @(posedge clk) begin
        cpa_q <= cpa_d;
    end

    assign s_o  = cpa_q.s;
    assign c_o  = cpa_q.c;
    assign r_o  = cpa_q.r;
    assign cy_o = cpa_q.cy;

endmodule

// File: rtl/smul_bw_pipe.sv
module smul_bw_pipe #(
    parameter int unsigned OP_W    = 8,
    parameter int unsigned LATENCY = 17
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op_a,
    input  logic [OP_W-1:0]     op_b,
    output logic                out_valid,
    output logic [2*OP_W-1:0]   product
);
    import smul_pkg::*;

    localparam int unsigned PW      = 2 * OP_W;
    localparam int unsigned ROWS    = OP_W;
    localparam int unsigned CPA_STG = (LATENCY > ROWS + 1) ? (LATENCY - ROWS - 1) : 1;
    localparam int unsigned CH      = (PW + CPA_STG - 1) / CPA_STG;
    localparam int unsigned PADW    = CH * CPA_STG;
    localparam int unsigned TOTAL   = 1 + ROWS + CPA_STG;
    localparam logic [63:0] SEED64  = bw_seed(OP_W);

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
    } opnd_t;

    opnd_t            in_d, in_q;
    logic [TOTAL-1:0] vld_d, vld_q;

    always_comb begin
        in_d.a = op_a;
        in_d.b = op_b;
        vld_d  = rst ? '0 : {vld_q[TOTAL-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        in_q  <= in_d;
        vld_q <= vld_d;
    end

    // Carry-save array: one full-adder row per multiplier bit.
    logic [OP_W-1:0] ra [0:ROWS];
    logic [OP_W-1:0] rb [0:ROWS];
    logic [PW-1:0]   rs [0:ROWS];
    logic [PW-1:0]   rc [0:ROWS];

    assign ra[0] = in_q.a;
    assign rb[0] = in_q.b;
    assign rs[0] = SEED64[PW-1:0];
    assign rc[0] = '0;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        bw_row_stage #(.OP_W(OP_W), .ROW(g)) u_row (
            .clk (clk),
            .a_i (ra[g]),   .b_i (rb[g]),   .s_i (rs[g]),   .c_i (rc[g]),
            .a_o (ra[g+1]), .b_o (rb[g+1]), .s_o (rs[g+1]), .c_o (rc[g+1])
        );
    end

    // Sliced carry-propagate adder, one slice per stage.
    logic [PADW-1:0] cs  [0:CPA_STG];
    logic [PADW-1:0] cc  [0:CPA_STG];
    logic [PADW-1:0] cr  [0:CPA_STG];
    logic            ccy [0:CPA_STG];

    assign cs[0]  = PADW'(rs[ROWS]);
    assign cc[0]  = PADW'(rc[ROWS]);
    assign cr[0]  = '0;
    assign ccy[0] = 1'b0;

    for (genvar k = 0; k < CPA_STG; k++) begin : g_cpa
        bw_cpa_stage #(.PADW(PADW), .CH(CH), .STG(k)) u_cpa (
            .clk  (clk),
            .s_i  (cs[k]),   .c_i (cc[k]),   .r_i (cr[k]),   .cy_i (ccy[k]),
            .s_o  (cs[k+1]), .c_o (cc[k+1]), .r_o (cr[k+1]), .cy_o (ccy[k+1])
        );
    end

    assign product   = cr[CPA_STG][PW-1:0];
    assign out_valid = vld_q[TOTAL-1];

endmodule

// File: rtl/smul_bw_chk.sv
module smul_bw_chk #(
    parameter int unsigned OP_W    = 8,
    parameter int unsigned LATENCY = 17
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OP_W-1:0]     op_a,
    input logic [OP_W-1:0]     op_b,
    input logic                out_valid,
    input logic [2*OP_W-1:0]   product
);
    localparam int unsigned PW  = 2 * OP_W;
    localparam int unsigned LAT = (LATENCY > OP_W + 1) ? LATENCY : OP_W + 2;

    logic [LAT-1:0]  sh_v;
    logic [PW-1:0]   sh_p [0:LAT-1];
    logic [OP_W-1:0] sh_a [0:LAT-1];
    logic [OP_W-1:0] sh_b [0:LAT-1];
    logic [PW-1:0]   exp_now;

    assign exp_now = PW'($signed(op_a) * $signed(op_b));

    always_ff @(posedge clk) begin
        sh_v    <= rst ? '0 : {sh_v[LAT-2:0], in_valid};
        sh_p[0] <= exp_now;
        sh_a[0] <= op_a;
        sh_b[0] <= op_b;
        for (int i = 1; i < LAT; i++) begin
            sh_p[i] <= sh_p[i-1];
            sh_a[i] <= sh_a[i-1];
            sh_b[i] <= sh_b[i-1];
        end
    end

    // R1 / R2 / R3: each valid result is its own pair's product, LAT edges later
    a_r1_product_value: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> product == sh_p[LAT-1]);

    // R1: a flagged result never carries unknown bits
    a_r1_product_known: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(product));

    // R4: valid flag delayed by the full pipeline depth
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
        out_valid == sh_v[LAT-1]);

    // R5: a reset edge leaves no valid result behind it
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R6: most-negative squared gives the top positive power of two
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sh_a[LAT-1] == {1'b1, {(OP_W-1){1'b0}}}
                   && sh_b[LAT-1] == {1'b1, {(OP_W-1){1'b0}}})
        |-> product == {2'b01, {(PW-2){1'b0}}});

endmodule

bind smul_bw_pipe smul_bw_chk #(.OP_W(OP_W), .LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_smul_bw_pipe.sv
`timescale 1ns/1ps
module test_smul_bw_pipe;

    localparam int DEPTH = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        out_valid;
    logic [15:0] product;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic        h_v [0:DEPTH-1];
    logic [15:0] h_p [0:DEPTH-1];

    always #4 clk = ~clk;

    smul_bw_pipe i_smul_bw_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product)
    );

    // Reference history: entry 0 is the pair captured at the latest edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = DEPTH-1; i > 0; i--) begin
            h_v[i] <= rst ? 1'b0 : h_v[i-1];
            h_p[i] <= h_p[i-1];
        end
        h_v[0] <= rst ? 1'b0 : in_valid;
        h_p[0] <= 16'($signed(op_a) * $signed(op_b));
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at the falling edge: compare against the entry from 17 edges back.
    task automatic check_out(input string tag);
        chk({tag, " R4 valid"}, 16'(out_valid), 16'(h_v[DEPTH-1]));
        if (h_v[DEPTH-1] === 1'b1)
            chk({tag, " R1/R2 product"}, product, h_p[DEPTH-1]);
    endtask

    task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b,
                        input string tag);
        in_valid = v; op_a = a; op_b = b;
        @(negedge clk);
        check_out(tag);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin h_v[i] = 1'b0; h_p[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R5 valid low in reset", 16'(out_valid), 16'h0);
        rst = 1'b0;

        // R6: extreme operands back to back
        step(1, 8'h80, 8'h80, "R6 -128*-128");
        step(1, 8'h80, 8'h7f, "R6 -128*127");
        step(1, 8'h7f, 8'h7f, "R6 127*127");
        step(1, 8'hff, 8'hff, "R6 -1*-1");
        step(1, 8'h7f, 8'h80, "R6 127*-128");
        step(1, 8'h00, 8'h80, "R6 0*-128");
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 8'h00, "R6 drain");
        step(0, 8'h00, 8'h00, "R6 idle");

        // R6: explicit numeric checks independent of the history model
        in_valid = 1; op_a = 8'h80; op_b = 8'h80;
        @(negedge clk); in_valid = 0;
        repeat (DEPTH-1) @(negedge clk);
        chk("R6 -128*-128 valid", 16'(out_valid), 16'h1);
        chk("R6 -128*-128 = 16384", product, 16'h4000);
        @(negedge clk);
        chk("R2 single pulse ends", 16'(out_valid), 16'h0);

        // R1 R3: exhaustive sweep, one new pair every clock
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1, 8'(a), 8'(b), "R1 R3 sweep");

        // R4: gapped traffic, garbage operands while invalid
        for (int i = 0; i < 300; i++)
            step(((i % 3) == 1) || ((i % 7) == 0), 8'(i * 37 + 5), 8'(i * 91 + 3),
                 "R4 gaps");

        // R5: reset while the pipeline is full
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 13), 8'(200 - i), "R5 fill");
        in_valid = 1; rst = 1;
        @(negedge clk);
        chk("R5 cleared after reset edge", 16'(out_valid), 16'h0);
        rst = 0;
        for (int i = 0; i < DEPTH; i++) begin
            in_valid = 0;
            @(negedge clk);
            chk("R5 stays clear", 16'(out_valid), 16'h0);
        end
        for (int i = 0; i < DEPTH + 4; i++) step(1, 8'(i * 29), 8'(i * 71), "R5 resume");
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 8'h00, "R4 final drain");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule